// File: doc/BRIEF.md
# Eight-Bit Addressable Latch

This block keeps eight single-bit storage elements that a 3-bit index selects one at a time. A single serial data bit is loaded into the selected element while the active-low gate is low. Every other element is left alone, unless the active-low clear is also low, in which case the others are zeroed. With the gate high the clear input either wipes all eight bits or, when it is high too, leaves every bit frozen. With gate and clear both low the block becomes a 3-to-8 demultiplexer: only the selected output can be high, and it shows the data bit.

The level behaviour is modelled on a clock. Inputs are sampled on every rising edge, and the stored state is updated from a combinational next-state function. The outputs are a combinational view of that state. While the gate is low, the selected output shows the data input at once. While clear is low, the unselected outputs read zero at once. The bit that a write leaves behind is the data value sampled at the last rising edge before the gate goes high again. At power-up the stored value is undefined until the block has seen one cycle with clear low.

Top module: `addr_latch8`

## Requirements
- R1: The select input is an unsigned binary index. Bit 0 is its least significant bit, and value k selects output bit k.
- R2: While gate_n is low, output bit bit_sel equals data_in in the same cycle, whatever clear_n is.
- R3: After a rising clock edge that samples gate_n low and clear_n high, the selected bit holds the data_in value sampled at that edge. Once gate_n is high, that bit keeps the value.
- R4: With gate_n low and clear_n high, every output bit other than the selected one keeps its stored value across the edge.
- R5: With gate_n high and clear_n high, all eight outputs keep their stored values, whatever data_in or bit_sel do, including when bit_sel changes.
- R6: With gate_n high and clear_n low, all outputs read 0 in that cycle, and the stored state is 0 after the edge.
- R7: With gate_n low and clear_n low, the output equals data_in shifted left by bit_sel. Every unselected bit is 0, and the stored state takes the same value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| data_in | input | 1 | Serial data bit |
| bit_sel | input | 3 | Index of the element to load, bit 0 least significant |
| gate_n | input | 1 | Active-low load gate |
| clear_n | input | 1 | Active-low clear, sampled synchronously |
| q_out | output | 8 | Parallel outputs |

## Verification
The bench sweeps every index with both data values in write mode and in decode mode. A decoder with reversed select bits puts the data on the mirrored output, and one that ignores clear leaves stale ones where decode mode needs zeros. It then moves the index and the data while the gate is high. A design that stays transparent when the gate is high, or that misses the edge at which a bit is stored, ends up with a different pattern. A clear issued after a full pattern has been loaded shows whether every bit is wiped or only some of them.

// File: rtl/addr_latch_pkg.sv
// Package: operating modes shared by the addressable latch modules.
// Assumes: the mode is derived only from gate_n and clear_n.
package addr_latch_pkg;

    typedef enum logic [1:0] {
        MODE_WRITE  = 2'd0,
        MODE_HOLD   = 2'd1,
        MODE_DECODE = 2'd2,
        MODE_CLEAR  = 2'd3
    } mode_e;

endpackage

// File: rtl/alatch_mode_dec.sv
// Module: turns the two active-low controls into one of four modes.
// Assumes: both controls are already synchronous to clk.
module alatch_mode_dec
    import addr_latch_pkg::*;
(
    input  logic  gate_n,
    input  logic  clear_n,
    output mode_e mode
);

    // Map the control pair onto a mode.
    always_comb begin
        unique case ({gate_n, clear_n})
            2'b01:   mode = MODE_WRITE;
            2'b00:   mode = MODE_DECODE;
            2'b10:   mode = MODE_CLEAR;
            default: mode = MODE_HOLD;
        endcase
    end

endmodule

// File: rtl/alatch_decoder.sv
// Module: binary index to one-hot select vector.
// Assumes: the index is unsigned, with bit 0 as its least significant bit.
module alatch_decoder #(
    parameter int ADDR_W = 3,
    localparam int N     = 1 << ADDR_W
) (
    input  logic [ADDR_W-1:0] index,
    output logic [N-1:0]      hit
);

    for (genvar i = 0; i < N; i++) begin : g_hit
        // Raise one line when the index matches its position.
        assign hit[i] = (index == ADDR_W'(i));
    end

endmodule

// File: rtl/alatch_cell.sv
// Module: one storage bit with its next-state function and output view.
// Assumes: the stored value is undefined until the first clear mode or write.
module alatch_cell
    import addr_latch_pkg::*;
(
    input  logic  clk,
    input  mode_e mode,
    input  logic  hit,
    input  logic  din,
    output logic  view
);

    logic stored;
    logic nxt;

    // Next stored value for the current mode.
    always_comb begin
        unique case (mode)
            MODE_WRITE:  nxt = hit ? din : stored;
            MODE_DECODE: nxt = hit ? din : 1'b0;
            MODE_CLEAR:  nxt = 1'b0;
            default:     nxt = stored;
        endcase
    end

    // Combinational output: transparent when selected, zero under clear.
    always_comb begin
        unique case (mode)
            MODE_WRITE:  view = hit ? din : stored;
            MODE_DECODE: view = hit ? din : 1'b0;
            MODE_CLEAR:  view = 1'b0;
            default:     view = stored;
        endcase
    end

    // Store the next value on every rising edge.
    always_ff @(posedge clk) begin
        stored <= nxt;
    end

endmodule

// File: rtl/addr_latch8.sv
// Module: eight individually addressable bits with write, hold, decode and
// clear modes. clear_n acts as the synchronous active-low reset of the state.
// Assumes: bit_sel changes only while gate_n is high, if no glitch on the
// selected bit is wanted.
module addr_latch8
    import addr_latch_pkg::*;
#(
    parameter int ADDR_W = 3,
    localparam int N     = 1 << ADDR_W
) (
    input  logic              clk,
    input  logic              data_in,
    input  logic [ADDR_W-1:0] bit_sel,
    input  logic              gate_n,
    input  logic              clear_n,
    output logic [N-1:0]      q_out
);

    mode_e        mode;
    logic [N-1:0] hit;

    alatch_mode_dec u_mode (
        .gate_n  (gate_n),
        .clear_n (clear_n),
        .mode    (mode)
    );

    alatch_decoder #(.ADDR_W(ADDR_W)) u_dec (
        .index (bit_sel),
        .hit   (hit)
    );

    for (genvar i = 0; i < N; i++) begin : g_cell
        alatch_cell u_cell (
            .clk  (clk),
            .mode (mode),
            .hit  (hit[i]),
            .din  (data_in),
            .view (q_out[i])
        );
    end

endmodule

// File: rtl/addr_latch8_chk.sv
// Module: protocol checker for addr_latch8, bound to every instance.
// Assumes: checks start one edge after the first cycle with clear_n low.
module addr_latch8_chk #(
    parameter int ADDR_W = 3,
    localparam int N     = 1 << ADDR_W
) (
    input logic              clk,
    input logic              data_in,
    input logic [ADDR_W-1:0] bit_sel,
    input logic              gate_n,
    input logic              clear_n,
    input logic [N-1:0]      q_out
);

    localparam logic [N-1:0] ONE = N'(1);

    logic armed = 1'b0;

    // Arm the checks once the state has been cleared.
    always_ff @(posedge clk) begin
        if (!clear_n) armed <= 1'b1;
    end

    AST_SEL_FOLLOWS: assert property (@(posedge clk) disable iff (!armed)
        !gate_n |-> (q_out[bit_sel] == data_in)); // R2

    AST_WRITE_STORES: assert property (@(posedge clk) disable iff (!armed)
        ($past(!gate_n && clear_n) && gate_n && clear_n)
        |-> ((q_out & (ONE << $past(bit_sel))) ==
             ({N{$past(data_in)}} & (ONE << $past(bit_sel))))); // R3

    AST_WRITE_OTHERS: assert property (@(posedge clk) disable iff (!armed)
        ($past(!gate_n && clear_n) && gate_n && clear_n)
        |-> ((q_out & ~(ONE << $past(bit_sel))) ==
             ($past(q_out) & ~(ONE << $past(bit_sel))))); // R4

    AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!armed)
        ($past(gate_n && clear_n) && gate_n && clear_n) |-> $stable(q_out)); // R5

    AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!armed)
        (gate_n && !clear_n) |-> (q_out == '0)); // R6

    AST_DECODE_ONEHOT: assert property (@(posedge clk) disable iff (!armed)
        (!gate_n && !clear_n) |-> ($onehot0(q_out) &&
                                   (q_out == ({N{data_in}} & (ONE << bit_sel))))); // R7

endmodule

bind addr_latch8 addr_latch8_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk     (clk),
    .data_in (data_in),
    .bit_sel (bit_sel),
    .gate_n  (gate_n),
    .clear_n (clear_n),
    .q_out   (q_out)
);

// File: tb/addr_latch8_tb.sv
// Bench: sweeps all modes with an arithmetic reference of the eight bits.
module addr_latch8_tb;

    logic       clk = 1'b0;
    logic       data_in = 1'b0;
    logic [2:0] bit_sel = 3'd0;
    logic       gate_n = 1'b1;
    logic       clear_n = 1'b1;
    logic [7:0] q_out;

    logic [7:0] model = 8'h00;
    int         n_run = 0;
    int         n_fail = 0;

    always #5 clk = ~clk;

    addr_latch8 u_dut (
        .clk     (clk),
        .data_in (data_in),
        .bit_sel (bit_sel),
        .gate_n  (gate_n),
        .clear_n (clear_n),
        .q_out   (q_out)
    );

    // Expected combinational view for the given inputs.
    function automatic logic [7:0] view_of(logic [7:0] m, logic d, logic [2:0] a,
                                           logic g, logic c);
        logic [7:0] v;
        v = c ? m : 8'h00;
        if (!g) v[a] = d;
        return v;
    endfunction

    task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: q_out=%b expected=%b", tag, act, exp);
        end
    endtask

    // Drive one cycle, check the view before the edge, then advance the model.
    task automatic step(string tag, logic d, logic [2:0] a, logic g, logic c);
        @(negedge clk);
        data_in = d; bit_sel = a; gate_n = g; clear_n = c;
        #2;
        check(tag, q_out, view_of(model, d, a, g, c));
        @(posedge clk);
        model = view_of(model, d, a, g, c);
    endtask

    initial begin
        #1500000;
        n_fail++;
        $display("FAIL watchdog: q_out=%b expected=done", q_out);
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        // R6: clear from an unknown state.
        step("R6 clear", 1'b1, 3'd5, 1'b1, 1'b0);
        step("R5 hold after clear", 1'b1, 3'd2, 1'b1, 1'b1);

        // R1: index 1 reaches output bit 1 only.
        step("R1 write idx1", 1'b1, 3'd1, 1'b0, 1'b1);
        step("R1 hold", 1'b0, 3'd1, 1'b1, 1'b1);
        check("R1 bit order", q_out, 8'b0000_0010);

        // R2/R3/R4: every index with both data values, alternating patterns.
        for (int a = 0; a < 8; a++) begin
            for (int k = 0; k < 2; k++) begin
                logic d;
                d = logic'((a + k) & 1);
                step("R2 write", ~d, 3'(a), 1'b0, 1'b1);
                step("R2 write", d, 3'(a), 1'b0, 1'b1);
                step("R3 R4 stored", ~d, 3'(a), 1'b1, 1'b1);
            end
        end

        // R5: move index and data with the gate high.
        for (int i = 0; i < 16; i++)
            step("R5 hold sweep", logic'(i & 1), 3'(i >> 1), 1'b1, 1'b1);

        // R6: wipe a nonzero pattern.
        step("R6 clear pattern", 1'b1, 3'd3, 1'b1, 1'b0);
        step("R6 cleared", 1'b0, 3'd4, 1'b1, 1'b1);
        check("R6 state zero", q_out, 8'h00);

        // R7: decode every index, starting from a full pattern.
        for (int a = 0; a < 8; a++) step("R4 fill", 1'b1, 3'(a), 1'b0, 1'b1);
        for (int a = 0; a < 8; a++) begin
            for (int d = 0; d < 2; d++) begin
                step("R7 decode", logic'(d), 3'(a), 1'b0, 1'b0);
                check("R7 shift", q_out, 8'(d) << a);
            end
        end
        step("R7 decode kept", 1'b0, 3'd0, 1'b1, 1'b1);
        check("R7 stored", q_out, 8'b1000_0000);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule